// File: doc/BRIEF.md
# Infrared receiver status register

This block holds the eight-bit receive status word of a serial infrared receiver. The receive datapath does the line decoding, the CRC check and the FIFO storage. It reports what it sees as single-cycle event strobes: start flag, stop flag, abort sequence, CRC or alignment error, FIFO push, preamble and enter-hunt command. It also drives level inputs for FIFO full, FIFO not empty and the high-rate mode. The block keeps each status bit under its own set and clear rule.

The host samples the word with a one-cycle read strobe. The block also raises an interrupt when the sync/hunt state changes and that interrupt is enabled.

The error bits and the end-of-frame bit clear when the start flag of the next packet arrives. The sync/hunt bit works in one of two ways, chosen by the interrupt enable. With the enable set, it is a change flag that a read clears. With the enable clear, it shows the current sync/hunt level. The read port is a plain strobe and register with no back-pressure. A read is always accepted, and its result appears on the cycle after the strobe.

Top module: `ir_rx_status`

## Requirements
- R1: The word has these fields: bit 7 abort, bit 6 CRC/alignment error, bit 5 overflow, bit 4 end of frame, bit 3 FIFO data available, bit 2 sync/hunt, and bits 1:0 always 0. A read strobe sampled at a clock edge loads the word into `rd_data_o` at that same edge.
- R2: After reset, with the interrupt enable clear, a read returns 0x04 and `irq_o` is 0.
- R3: A CRC error strobe sets bit 6. A start flag clears it. When both arrive in the same cycle, bit 6 is set.
- R4: A stop flag or an abort strobe sets bit 4. A start flag clears it. When a set and a start arrive in the same cycle, bit 4 is set.
- R5: An abort strobe sets bit 7. The bit stays set until a start flag arrives. When both arrive in the same cycle, bit 7 is set.
- R6: A FIFO push while FIFO full is high sets bit 5. A push while FIFO full is low leaves bit 5 unchanged. A start flag clears bit 5, and a set in the same cycle wins over the clear.
- R7: Bit 3 equals the FIFO not-empty input in the cycle of the read, and it never affects `irq_o`.
- R8: The sync/hunt level is 1 for hunting and resets to 1. An enter-hunt command or a stop flag drives it to 1. If neither is present, a start flag drives it to 0, and so does a preamble strobe while high-rate mode is 1. A preamble while high-rate mode is 0 has no effect.
- R9: With the interrupt enable clear, bit 2 shows the live sync/hunt level and `irq_o` is 0. Reads in this mode do not clear the change flag, so a change that is still pending raises `irq_o` as soon as the enable is set.
- R10: Every change of the sync/hunt level sets the change flag. With the enable set, bit 2 shows the flag and `irq_o` equals the flag. A read clears the flag, except when a new change arrives in the same cycle; then the flag stays set.
- R11: A read returns the word as it was before that read's clear takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_flag_i | input | 1 | Start flag detected (strobe) |
| stop_flag_i | input | 1 | Stop flag detected (strobe) |
| abort_i | input | 1 | Abort sequence detected (strobe) |
| crc_err_i | input | 1 | CRC or alignment error detected (strobe) |
| fifo_push_i | input | 1 | Receive byte written toward the FIFO (strobe) |
| fifo_full_i | input | 1 | FIFO full level |
| fifo_nonempty_i | input | 1 | FIFO holds data (level) |
| hunt_cmd_i | input | 1 | Enter-hunt command (strobe) |
| preamble_i | input | 1 | Valid preamble detected (strobe) |
| high_rate_i | input | 1 | High-rate line mode selected (level) |
| sync_irq_en_i | input | 1 | Sync/hunt change interrupt enable |
| rd_i | input | 1 | Host read strobe, one cycle |
| rd_data_o | output | 8 | Word captured by the last read |
| irq_o | output | 1 | Sync/hunt change interrupt |

## Verification
The assertions assume the following about the inputs:
- Every event input is a single-cycle strobe sampled at the rising edge.
- `rd_i` never stays high into a second cycle.
- `fifo_full_i` matters only in a cycle with a push.

The stimulus drives every input at the falling edge and drops each strobe after one cycle. Reads are spaced by at least one idle cycle. Cases that collide in one cycle are driven on purpose, because the rule for each collision is stated: set against start, a level change against a read, and hunt against start.

// File: rtl/ir_rx_status_pkg.sv
package ir_rx_status_pkg;
  localparam int STAT_W    = 8;
  localparam int BIT_ABORT = 7;
  localparam int BIT_CRC   = 6;
  localparam int BIT_OVF   = 5;
  localparam int BIT_EOF   = 4;
  localparam int BIT_AVAIL = 3;
  localparam int BIT_SYNC  = 2;
  localparam int RSV_W     = BIT_SYNC;

  localparam int N_STICKY  = 4;
  localparam int STK_ABORT = 3;
  localparam int STK_CRC   = 2;
  localparam int STK_OVF   = 1;
  localparam int STK_EOF   = 0;

  localparam logic HUNT_LVL = 1'b1;
  localparam logic SYNC_LVL = 1'b0;
endpackage

// File: rtl/irs_sticky_bank.sv
module irs_sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i)    q <= 1'b0;
    end
    assign q_o[g] = q;
  end
endmodule

// File: rtl/irs_sync_tracker.sv
module irs_sync_tracker
  import ir_rx_status_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hunt_cmd_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic preamble_i,
  input  logic high_rate_i,
  input  logic rd_clr_i,
  output logic level_o,
  output logic chg_o,
  output logic evt_o
);
  logic level_q, level_d, chg_q;
  logic to_hunt, to_sync;

  always_comb begin
    to_hunt = hunt_cmd_i | stop_i;
    to_sync = start_i | (preamble_i & high_rate_i);
    if (to_hunt)      level_d = HUNT_LVL;
    else if (to_sync) level_d = SYNC_LVL;
    else              level_d = level_q;
  end

  assign evt_o = (level_d != level_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= HUNT_LVL;
      chg_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      if (evt_o)         chg_q <= 1'b1;
      else if (rd_clr_i) chg_q <= 1'b0;
    end
  end

  assign level_o = level_q;
  assign chg_o   = chg_q;
endmodule

// File: rtl/irs_read_port.sv
module irs_read_port
  import ir_rx_status_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_STICKY-1:0] sticky_i,
  input  logic                avail_i,
  input  logic                level_i,
  input  logic                chg_i,
  input  logic                irq_en_i,
  input  logic                rd_i,
  output logic [STAT_W-1:0]   word_o,
  output logic [STAT_W-1:0]   rd_data_o
);
  logic [STAT_W-1:0] rd_q;

  always_comb begin
    word_o            = '0;
    word_o[BIT_ABORT] = sticky_i[STK_ABORT];
    word_o[BIT_CRC]   = sticky_i[STK_CRC];
    word_o[BIT_OVF]   = sticky_i[STK_OVF];
    word_o[BIT_EOF]   = sticky_i[STK_EOF];
    word_o[BIT_AVAIL] = avail_i;
    word_o[BIT_SYNC]  = irq_en_i ? chg_i : level_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rd_q <= '0;
    else if (rd_i) rd_q <= word_o;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/ir_rx_status.sv
module ir_rx_status
  import ir_rx_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_flag_i,
  input  logic              stop_flag_i,
  input  logic              abort_i,
  input  logic              crc_err_i,
  input  logic              fifo_push_i,
  input  logic              fifo_full_i,
  input  logic              fifo_nonempty_i,
  input  logic              hunt_cmd_i,
  input  logic              preamble_i,
  input  logic              high_rate_i,
  input  logic              sync_irq_en_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [N_STICKY-1:0] sticky_set, sticky_q;
  logic                sync_level, sync_chg, sync_evt;
  logic [STAT_W-1:0]   stat_word;

  always_comb begin
    sticky_set            = '0;
    sticky_set[STK_ABORT] = abort_i;
    sticky_set[STK_CRC]   = crc_err_i;
    sticky_set[STK_OVF]   = fifo_push_i & fifo_full_i;
    sticky_set[STK_EOF]   = stop_flag_i | abort_i;
  end

  irs_sticky_bank #(.N(N_STICKY)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sticky_set),
    .clr_i (start_flag_i),
    .q_o   (sticky_q)
  );

  irs_sync_tracker u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .hunt_cmd_i  (hunt_cmd_i),
    .start_i     (start_flag_i),
    .stop_i      (stop_flag_i),
    .preamble_i  (preamble_i),
    .high_rate_i (high_rate_i),
    .rd_clr_i    (rd_i & sync_irq_en_i),
    .level_o     (sync_level),
    .chg_o       (sync_chg),
    .evt_o       (sync_evt)
  );

  irs_read_port u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .sticky_i  (sticky_q),
    .avail_i   (fifo_nonempty_i),
    .level_i   (sync_level),
    .chg_i     (sync_chg),
    .irq_en_i  (sync_irq_en_i),
    .rd_i      (rd_i),
    .word_o    (stat_word),
    .rd_data_o (rd_data_o)
  );

  assign irq_o = sync_chg & sync_irq_en_i;
endmodule

// File: rtl/ir_rx_status_chk.sv
module ir_rx_status_chk
  import ir_rx_status_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_flag_i,
  input logic              stop_flag_i,
  input logic              abort_i,
  input logic              crc_err_i,
  input logic              fifo_push_i,
  input logic              fifo_full_i,
  input logic              sync_irq_en_i,
  input logic              rd_i,
  input logic              sync_evt,
  input logic [STAT_W-1:0] stat_word,
  input logic [STAT_W-1:0] rd_data_o,
  input logic              irq_o
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[RSV_W-1:0] == '0);

  assert_crc_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err_i |=> stat_word[BIT_CRC]);

  assert_crc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_flag_i && !crc_err_i) |=> !stat_word[BIT_CRC]);

  assert_eof_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_flag_i || abort_i) |=> stat_word[BIT_EOF]);

  assert_abort_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[BIT_ABORT] && !start_flag_i) |=> stat_word[BIT_ABORT]);

  assert_overflow_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push_i && fifo_full_i) |=> stat_word[BIT_OVF]);

  assert_irq_off_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_irq_en_i |-> !irq_o);

  assert_read_clears_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sync_irq_en_i && !sync_evt) |=> !irq_o);

  assert_change_raises_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_evt && sync_irq_en_i) |=> (irq_o || !sync_irq_en_i));

  assert_read_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rd_data_o == $past(stat_word));
endmodule

bind ir_rx_status ir_rx_status_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_flag_i  (start_flag_i),
  .stop_flag_i   (stop_flag_i),
  .abort_i       (abort_i),
  .crc_err_i     (crc_err_i),
  .fifo_push_i   (fifo_push_i),
  .fifo_full_i   (fifo_full_i),
  .sync_irq_en_i (sync_irq_en_i),
  .rd_i          (rd_i),
  .sync_evt      (sync_evt),
  .stat_word     (stat_word),
  .rd_data_o     (rd_data_o),
  .irq_o         (irq_o)
);

// File: tb/ir_rx_status_tb_top.sv
module ir_rx_status_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_flag_i = 0, stop_flag_i = 0, abort_i = 0, crc_err_i = 0;
  logic fifo_push_i = 0, fifo_full_i = 0, fifo_nonempty_i = 0;
  logic hunt_cmd_i = 0, preamble_i = 0, high_rate_i = 0;
  logic sync_irq_en_i = 0, rd_i = 0;
  logic [7:0] rd_data_o;
  logic irq_o;

  always #(CLK_P/2) clk = ~clk;

  ir_rx_status dut_i (
    .clk(clk), .rst_n(rst_n),
    .start_flag_i(start_flag_i), .stop_flag_i(stop_flag_i),
    .abort_i(abort_i), .crc_err_i(crc_err_i),
    .fifo_push_i(fifo_push_i), .fifo_full_i(fifo_full_i),
    .fifo_nonempty_i(fifo_nonempty_i), .hunt_cmd_i(hunt_cmd_i),
    .preamble_i(preamble_i), .high_rate_i(high_rate_i),
    .sync_irq_en_i(sync_irq_en_i), .rd_i(rd_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb_q[$];
  string cur_tag = "R2";

  logic m_ab = 0, m_crc = 0, m_ovf = 0, m_eof = 0, m_lvl = 1, m_chg = 0;

  function automatic logic [7:0] model_word();
    return {m_ab, m_crc, m_ovf, m_eof, fifo_nonempty_i,
            sync_irq_en_i ? m_chg : m_lvl, 2'b00};
  endfunction

  // one cycle: expected read pushed, model advanced, strobes dropped
  task automatic tick();
    logic lvl_n;
    exp_t e;
    if (rd_i) begin
      e.exp = model_word();
      e.tag = cur_tag;
      sb_q.push_back(e);
    end
    lvl_n = (hunt_cmd_i | stop_flag_i) ? 1'b1 :
            (start_flag_i | (preamble_i & high_rate_i)) ? 1'b0 : m_lvl;
    m_ab  = abort_i ? 1'b1 : (start_flag_i ? 1'b0 : m_ab);
    m_crc = crc_err_i ? 1'b1 : (start_flag_i ? 1'b0 : m_crc);
    m_ovf = (fifo_push_i & fifo_full_i) ? 1'b1 : (start_flag_i ? 1'b0 : m_ovf);
    m_eof = (stop_flag_i | abort_i) ? 1'b1 : (start_flag_i ? 1'b0 : m_eof);
    m_chg = (lvl_n != m_lvl) ? 1'b1 : ((rd_i & sync_irq_en_i) ? 1'b0 : m_chg);
    m_lvl = lvl_n;
    @(negedge clk);
    start_flag_i = 0; stop_flag_i = 0; abort_i = 0; crc_err_i = 0;
    fifo_push_i = 0; hunt_cmd_i = 0; preamble_i = 0; rd_i = 0;
  endtask

  task automatic do_read(input string tag);
    cur_tag = tag;
    rd_i = 1;
    tick();
    tick();
  endtask

  task automatic chk_irq(input string tag);
    logic e;
    e = m_chg & sync_irq_en_i;
    checks++;
    if (irq_o !== e) begin
      failures++;
      $display("FAIL %s irq_o actual=%0b expected=%0b", tag, irq_o, e);
    end
  endtask

  // monitor: compares each captured read against the scoreboard
  logic mon_fire = 0;
  always @(posedge clk) mon_fire <= rd_i;
  always @(negedge clk) begin
    if (mon_fire && rst_n) begin
      if (sb_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R1 unexpected read result actual=%h expected=none", rd_data_o);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (rd_data_o !== e.exp) begin
          failures++;
          $display("FAIL %s rd_data_o actual=%h expected=%h", e.tag, rd_data_o, e.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk_irq("R2");
    do_read("R2");
    // R1 / R3 crc set, field position
    crc_err_i = 1; tick();
    do_read("R3");
    // R3 start clears crc (start also syncs, R8)
    start_flag_i = 1; tick();
    do_read("R3");
    // R3 set wins over start
    crc_err_i = 1; start_flag_i = 1; tick();
    do_read("R3");
    // R4 stop sets eof and returns to hunt
    start_flag_i = 1; tick();
    stop_flag_i = 1; tick();
    do_read("R4");
    // R5 abort sets abort and eof, sticky
    abort_i = 1; tick();
    tick(); tick();
    do_read("R5");
    start_flag_i = 1; tick();
    do_read("R5");
    abort_i = 1; start_flag_i = 1; tick();
    do_read("R5");
    // R6 overflow
    start_flag_i = 1; tick();
    fifo_push_i = 1; fifo_full_i = 0; tick();
    do_read("R6");
    fifo_push_i = 1; fifo_full_i = 1; tick();
    fifo_full_i = 0;
    do_read("R6");
    start_flag_i = 1; tick();
    do_read("R6");
    // R7 available bit follows level, no irq
    fifo_nonempty_i = 1;
    do_read("R7");
    chk_irq("R7");
    fifo_nonempty_i = 0;
    do_read("R7");
    // R8 preamble ignored at low rate, taken at high rate
    hunt_cmd_i = 1; tick();
    high_rate_i = 0; preamble_i = 1; tick();
    do_read("R8");
    high_rate_i = 1; preamble_i = 1; tick();
    do_read("R8");
    // R8 hunt wins over start
    hunt_cmd_i = 1; start_flag_i = 1; tick();
    do_read("R8");
    // R9 reads with enable clear keep the change flag
    do_read("R9");
    chk_irq("R9");
    sync_irq_en_i = 1;
    #1 chk_irq("R9");
    // R10/R11 read returns pre-clear value then clears
    do_read("R11");
    chk_irq("R10");
    do_read("R10");
    // R10 new change raises irq
    start_flag_i = 1; tick();
    chk_irq("R10");
    // R10 change in same cycle as read: flag stays
    rd_i = 1; stop_flag_i = 1; cur_tag = "R10"; tick();
    tick();
    chk_irq("R10");
    do_read("R10");
    chk_irq("R10");
    sync_irq_en_i = 0;
    do_read("R9");
    repeat (3) tick();
    checks++;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R1 pending reads actual=%0d expected=0", sb_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule